// File: doc/BRIEF.md
# Flash Unlock Command Decoder

This block models the device side of a 16-bit parallel NOR flash. The host issues write cycles, each one an address and a data word, pulsed by `wr_stb` for one clock. A sequence decoder watches these writes for exact unlock handshakes. A handshake can lead to a word program, a whole-array erase, entry into an identification read mode, or arming a lock on the low boot region. Any write that does not match the next expected step sends the decoder back to idle with nothing changed.

The array is a small word-addressed register store that resets to the erased value FFFFh. A program can only clear bits, because the stored word becomes old AND new. An erase returns every word to FFFFh. Each program or erase holds `busy` for a parameterised number of clocks. While `busy` is high, reads return a status word in place of array data and the decoder accepts no writes.

Reads are combinational. Data is driven only while chip enable and output enable are both low.

Top module: `flash_cmd_decoder`

## Requirements
- R1: The writes 5555h/AAh, 2AAAh/55h and 5555h/A0h, followed by one write of address and data, store (old AND data) at word address addr[ADDR_W-1:0]. Programming never sets a bit.
- R2: The writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h and 5555h/10h set every array word to FFFFh.
- R3: The writes 5555h/AAh, 2AAAh/55h and 5555h/90h enter identification mode. In that mode a read at addr[1:0]=0 returns MFR_ID, at 1 returns DEV_ID, at 2 returns {15'b0, lock}, and at 3 returns 0. Any write whose low byte is F0h leaves the mode, and no other write is acted on while in it.
- R4: The erase prefix followed by 5555h/40h sets a lock that stays set until reset. While the lock is set, a program to a word address below BOOT_WORDS is dropped: the word is unchanged and `busy` stays low. Programs to other addresses still work.
- R5: `rdata_en` is 1 exactly when `ce_n` and `oe_n` are both 0. Otherwise `rdata` is 0000h.
- R6: While busy, a read returns bit 15 = NOT data[15] and bit 7 = NOT data[7], where data is the requested program word, or FFFFh for an erase. Bits 13..8 and 5..0 read 0.
- R7: While busy, bits 14 and 6 both carry a toggle value. It is 0 when the operation starts and inverts at the clock edge after each read start. A read start is a cycle in which `ce_n` and `oe_n` are both low after a cycle in which they were not.
- R8: `busy` rises at the clock edge that accepts the final write of a program or erase and stays high for exactly BUSY_CYCLES cycles. Writes made while busy are ignored.
- R9: A write that does not match the next expected step returns the decoder to idle. It has no effect on the array, the lock or the mode.
- R10: Command steps compare only addr[14:0] and wdata[7:0].
- R11: After reset, `busy` is 0, the lock is clear, identification mode is off and every word reads FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle write strobe |
| addr | input | 16 | Word address for writes and reads |
| wdata | input | 16 | Write data |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| rdata | output | 16 | Read data, status or identification word |
| rdata_en | output | 1 | High while read data is driven |
| busy | output | 1 | Program or erase in progress |

## Verification
The assertions check the following on every cycle:
- a program never raises a stored bit;
- an erase leaves FFFFh behind;
- a locked boot word keeps its value;
- the lock never falls once set;
- the decoder stays idle and no new operation starts while busy;
- identification mode and busy never coincide;
- each operation starts with the toggle value at 0.

The bench's scenarios are needed for the rest:
- the exact unlock orderings and the handshakes that break them;
- masking of the upper address bit and the high data byte;
- the length of the busy window;
- the values of the status and identification words;
- the toggle sequence over successive reads.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int BUS_W = 16;

    localparam logic [14:0] UNLK_A1 = 15'h5555;
    localparam logic [14:0] UNLK_A2 = 15'h2AAA;

    localparam logic [7:0] KEY1       = 8'hAA;
    localparam logic [7:0] KEY2       = 8'h55;
    localparam logic [7:0] OP_PROG    = 8'hA0;
    localparam logic [7:0] OP_EXT     = 8'h80;
    localparam logic [7:0] OP_ERASE   = 8'h10;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_LOCK    = 8'h40;
    localparam logic [7:0] OP_ID_EXIT = 8'hF0;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_K1,
        SQ_K2,
        SQ_PDATA,
        SQ_X3,
        SQ_X4,
        SQ_X5
    } seq_t;

    typedef struct packed {
        logic [BUS_W-1:0] addr;
        logic [BUS_W-1:0] data;
    } bus_wr_t;

    typedef struct packed {
        logic             prog;
        logic             erase;
        logic             lock;
        logic             id_on;
        logic             id_off;
        logic [BUS_W-1:0] addr;
        logic [BUS_W-1:0] data;
    } op_req_t;

    function automatic logic step_hit(bus_wr_t w, logic [14:0] a, logic [7:0] d);
        return (w.addr[14:0] == a) && (w.data[7:0] == d);
    endfunction

    function automatic logic [BUS_W-1:0] status_word(logic [BUS_W-1:0] ref_word, logic tog);
        return {~ref_word[15], tog, 6'b0, ~ref_word[7], tog, 6'b0};
    endfunction

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_cmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_stb,
    input  bus_wr_t wr,
    input  logic    block,
    input  logic    id_mode,
    output op_req_t req,
    output seq_t    state
);

    seq_t nxt;

    always_comb begin
        nxt      = state;
        req      = '0;
        req.addr = wr.addr;
        req.data = wr.data;
        if (wr_stb && !block) begin
            if (id_mode) begin
                nxt = SQ_IDLE;
                if (wr.data[7:0] == OP_ID_EXIT) req.id_off = 1'b1;
            end else begin
                case (state)
                    SQ_IDLE: nxt = step_hit(wr, UNLK_A1, KEY1) ? SQ_K1 : SQ_IDLE;
                    SQ_K1:   nxt = step_hit(wr, UNLK_A2, KEY2) ? SQ_K2 : SQ_IDLE;
                    SQ_K2: begin
                        if (step_hit(wr, UNLK_A1, OP_PROG))      nxt = SQ_PDATA;
                        else if (step_hit(wr, UNLK_A1, OP_EXT))  nxt = SQ_X3;
                        else if (step_hit(wr, UNLK_A1, OP_IDENT)) begin
                            req.id_on = 1'b1;
                            nxt       = SQ_IDLE;
                        end else begin
                            nxt = SQ_IDLE;
                        end
                    end
                    SQ_PDATA: begin
                        req.prog = 1'b1;
                        nxt      = SQ_IDLE;
                    end
                    SQ_X3: nxt = step_hit(wr, UNLK_A1, KEY1) ? SQ_X4 : SQ_IDLE;
                    SQ_X4: nxt = step_hit(wr, UNLK_A2, KEY2) ? SQ_X5 : SQ_IDLE;
                    SQ_X5: begin
                        if (step_hit(wr, UNLK_A1, OP_ERASE))     req.erase = 1'b1;
                        else if (step_hit(wr, UNLK_A1, OP_LOCK)) req.lock  = 1'b1;
                        nxt = SQ_IDLE;
                    end
                    default: nxt = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= nxt;
    end

    // R8: a busy device holds the decoder idle
    assert_idle_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
        block |-> (state == SQ_IDLE));

    // R3: identification mode keeps the decoder idle
    assert_idle_in_id_R3: assert property (@(posedge clk) disable iff (rst)
        id_mode |=> (state == SQ_IDLE));

endmodule

// File: rtl/flash_word_array.sv
module flash_word_array
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int BOOT_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog,
    input  logic              erase,
    input  logic              lock_set,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BUS_W-1:0]  rword,
    output logic              locked,
    output logic              prog_ok
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W:0] BOOT_LIM = (ADDR_W+1)'(BOOT_WORDS);

    logic [BUS_W-1:0] mem [DEPTH];
    logic             in_boot;

    assign in_boot = ({1'b0, waddr} < BOOT_LIM);
    assign prog_ok = prog && !(locked && in_boot);
    assign rword   = mem[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
        end else if (lock_set) begin
            locked <= 1'b1;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst || erase) begin
                    mem[gi] <= '1;
                end else if (prog_ok && (waddr == ADDR_W'(gi))) begin
                    mem[gi] <= mem[gi] & wdata;
                end
            end
        end
    endgenerate

    // R1: a program never raises a stored bit
    assert_no_set_R1: assert property (@(posedge clk) disable iff (rst)
        prog_ok |=> ((mem[$past(waddr)] & ~$past(mem[waddr])) == '0));

    // R2: an erase leaves the erased value at both ends of the array
    assert_erased_R2: assert property (@(posedge clk) disable iff (rst)
        erase |=> (mem[0] == '1) && (mem[DEPTH-1] == '1));

    // R4: the lock is sticky
    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    // R4: a locked boot word keeps its value
    assert_boot_kept_R4: assert property (@(posedge clk) disable iff (rst)
        (prog && locked && in_boot && !erase) |=> (mem[$past(waddr)] == $past(mem[waddr])));

endmodule

// File: rtl/flash_busy_ctrl.sv
module flash_busy_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int BUSY_CYCLES = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [BUS_W-1:0] ref_word,
    input  logic             rd_act,
    output logic             busy,
    output logic [BUS_W-1:0] status
);

    localparam int CW = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

    logic [CW-1:0]    cnt;
    logic             tog;
    logic             rd_prev;
    logic [BUS_W-1:0] held;

    assign busy   = (cnt != '0);
    assign status = status_word(held, tog);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            tog     <= 1'b0;
            rd_prev <= 1'b0;
            held    <= '1;
        end else begin
            rd_prev <= rd_act;
            if (start) begin
                cnt  <= LOAD;
                tog  <= 1'b0;
                held <= ref_word;
            end else begin
                if (busy) cnt <= cnt - 1'b1;
                if (busy && rd_act && !rd_prev) tog <= ~tog;
            end
        end
    end

    // R8: no new operation starts while one is running
    assert_no_restart_R8: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R7/R8: an accepted operation raises busy with the toggle value at 0
    assert_start_state_R7: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && (status[6] == 1'b0) && (status[14] == 1'b0)));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          BOOT_WORDS  = 16,
    parameter int          BUSY_CYCLES = 20,
    parameter logic [15:0] MFR_ID      = 16'h00DA,
    parameter logic [15:0] DEV_ID      = 16'h002C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_stb,
    input  logic [15:0] addr,
    input  logic [15:0] wdata,
    input  logic        ce_n,
    input  logic        oe_n,
    output logic [15:0] rdata,
    output logic        rdata_en,
    output logic        busy
);

    bus_wr_t          wr;
    op_req_t          req;
    seq_t             seq_state;
    logic             id_mode;
    logic             locked;
    logic             prog_ok;
    logic             start;
    logic [BUS_W-1:0] arr_word;
    logic [BUS_W-1:0] stat_word;
    logic [BUS_W-1:0] ref_word;
    logic [BUS_W-1:0] id_word;

    assign wr       = '{addr: addr, data: wdata};
    assign rdata_en = !ce_n && !oe_n;

    flash_seq_fsm u_seq (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr      (wr),
        .block   (busy),
        .id_mode (id_mode),
        .req     (req),
        .state   (seq_state)
    );

    flash_word_array #(
        .ADDR_W     (ADDR_W),
        .BOOT_WORDS (BOOT_WORDS)
    ) u_array (
        .clk      (clk),
        .rst      (rst),
        .prog     (req.prog),
        .erase    (req.erase),
        .lock_set (req.lock),
        .waddr    (req.addr[ADDR_W-1:0]),
        .wdata    (req.data),
        .raddr    (addr[ADDR_W-1:0]),
        .rword    (arr_word),
        .locked   (locked),
        .prog_ok  (prog_ok)
    );

    assign start    = prog_ok || req.erase;
    assign ref_word = req.erase ? '1 : req.data;

    flash_busy_ctrl #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_busy (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .ref_word (ref_word),
        .rd_act   (rdata_en),
        .busy     (busy),
        .status   (stat_word)
    );

    always_ff @(posedge clk) begin
        if (rst)             id_mode <= 1'b0;
        else if (req.id_on)  id_mode <= 1'b1;
        else if (req.id_off) id_mode <= 1'b0;
    end

    always_comb begin
        case (addr[1:0])
            2'd0:    id_word = MFR_ID;
            2'd1:    id_word = DEV_ID;
            2'd2:    id_word = {15'b0, locked};
            default: id_word = '0;
        endcase
    end

    always_comb begin
        if (!rdata_en)    rdata = '0;
        else if (busy)    rdata = stat_word;
        else if (id_mode) rdata = id_word;
        else              rdata = arr_word;
    end

    // R3: identification mode and a running operation never coincide
    assert_no_id_busy_R3: assert property (@(posedge clk) disable iff (rst)
        !(id_mode && busy));

    // R9/R3: entering identification mode starts no operation
    assert_id_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        req.id_on |=> !busy);

endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int BOOTW = 16;
    localparam int NBUSY = 12;
    localparam logic [15:0] MID = 16'h00DA;
    localparam logic [15:0] DID = 16'h002C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [15:0] rdata;
    logic        rdata_en;
    logic        busy;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R11";

    always #10 clk = ~clk;

    flash_cmd_decoder #(
        .ADDR_W      (AW),
        .BOOT_WORDS  (BOOTW),
        .BUSY_CYCLES (NBUSY),
        .MFR_ID      (MID),
        .DEV_ID      (DID)
    ) dut (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .addr     (addr),
        .wdata    (wdata),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .rdata    (rdata),
        .rdata_en (rdata_en),
        .busy     (busy)
    );

    // Behavioural reference model
    logic [15:0] m_mem [DEPTH];
    bit          m_lock, m_id, m_tog, m_rdprev;
    int          m_step;   // 0 idle,1 AA,2 55,3 await data,4 got 80,5 AA,6 55
    int          m_cnt;
    logic [15:0] m_ref;

    function automatic bit is_cmd(logic [15:0] a, logic [15:0] d, int ea, int ed);
        return (int'(a & 16'h7FFF) == ea) && (int'(d & 16'h00FF) == ed);
    endfunction

    always @(posedge clk) begin
        bit rd_now, was_busy, started;
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 16'hFFFF;
            m_lock = 0; m_id = 0; m_tog = 0; m_rdprev = 0;
            m_step = 0; m_cnt = 0; m_ref = 16'hFFFF;
        end else begin
            rd_now   = !ce_n && !oe_n;
            was_busy = (m_cnt > 0);
            started  = 0;
            if (wr_stb && !was_busy) begin
                if (m_id) begin
                    if ((wdata & 16'h00FF) == 16'h00F0) m_id = 0;
                    m_step = 0;
                end else begin
                    case (m_step)
                        0: m_step = is_cmd(addr, wdata, 'h5555, 'hAA) ? 1 : 0;
                        1: m_step = is_cmd(addr, wdata, 'h2AAA, 'h55) ? 2 : 0;
                        2: begin
                            if (is_cmd(addr, wdata, 'h5555, 'hA0))      m_step = 3;
                            else if (is_cmd(addr, wdata, 'h5555, 'h80)) m_step = 4;
                            else begin
                                if (is_cmd(addr, wdata, 'h5555, 'h90)) m_id = 1;
                                m_step = 0;
                            end
                        end
                        3: begin
                            if (!(m_lock && (addr % DEPTH) < BOOTW)) begin
                                m_mem[addr % DEPTH] = m_mem[addr % DEPTH] & wdata;
                                m_ref = wdata; started = 1;
                            end
                            m_step = 0;
                        end
                        4: m_step = is_cmd(addr, wdata, 'h5555, 'hAA) ? 5 : 0;
                        5: m_step = is_cmd(addr, wdata, 'h2AAA, 'h55) ? 6 : 0;
                        default: begin
                            if (is_cmd(addr, wdata, 'h5555, 'h10)) begin
                                for (int i = 0; i < DEPTH; i++) m_mem[i] = 16'hFFFF;
                                m_ref = 16'hFFFF; started = 1;
                            end else if (is_cmd(addr, wdata, 'h5555, 'h40)) begin
                                m_lock = 1;
                            end
                            m_step = 0;
                        end
                    endcase
                end
            end
            if (started) begin
                m_cnt = NBUSY; m_tog = 0;
            end else begin
                if (was_busy && rd_now && !m_rdprev) m_tog = !m_tog;
                if (m_cnt > 0) m_cnt--;
            end
            m_rdprev = rd_now;
        end
    end

    function automatic logic [15:0] model_rdata();
        if (ce_n || oe_n) return 16'h0000;
        if (m_cnt > 0) return {~m_ref[15], m_tog, 6'b0, ~m_ref[7], m_tog, 6'b0};
        if (m_id) begin
            case (addr[1:0])
                2'd0: return MID;
                2'd1: return DID;
                2'd2: return {15'b0, m_lock};
                default: return 16'h0000;
            endcase
        end
        return m_mem[addr % DEPTH];
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%04h expected=%04h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk({cur_req, " cycle busy R8"}, {15'b0, busy}, {15'b0, (m_cnt > 0)});
            chk({cur_req, " cycle rdata_en R5"}, {15'b0, rdata_en}, {15'b0, (!ce_n && !oe_n)});
            chk({cur_req, " cycle rdata"}, rdata, model_rdata());
        end
    end

    task automatic wr(logic [15:0] a, logic [15:0] d);
        @(posedge clk); #2;
        wr_stb = 1'b1; addr = a; wdata = d;
        @(posedge clk); #2;
        wr_stb = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, output logic [15:0] v);
        @(posedge clk); #2;
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        v = rdata;
        @(posedge clk); #2;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic prog_seq(logic [15:0] a, logic [15:0] d);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h00A0); wr(a, d);
    endtask

    task automatic ext_seq(logic [15:0] last);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0080);
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, last);
    endtask

    task automatic id_seq();
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0055); wr(16'h5555, 16'h0090);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int n;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;

        // R11 reset state
        cur_req = "R11";
        @(negedge clk);
        chk("R11 busy after reset", {15'b0, busy}, 16'h0);
        rd(16'h0005, v); chk("R11 erased word after reset", v, 16'hFFFF);

        // R5 output gating
        cur_req = "R5";
        @(posedge clk); #2 ce_n = 1'b0; oe_n = 1'b1; addr = 16'h0005;
        @(negedge clk);
        chk("R5 rdata with oe_n high", rdata, 16'h0000);
        chk("R5 rdata_en with oe_n high", {15'b0, rdata_en}, 16'h0);
        @(posedge clk); #2 ce_n = 1'b1; oe_n = 1'b0;
        @(negedge clk);
        chk("R5 rdata with ce_n high", rdata, 16'h0000);
        @(posedge clk); #2 oe_n = 1'b1;

        // R1 program and bit clearing only
        cur_req = "R1";
        prog_seq(16'h0005, 16'h1234); wait_idle();
        rd(16'h0005, v); chk("R1 programmed word", v, 16'h1234);
        prog_seq(16'h0005, 16'hFF0F); wait_idle();
        rd(16'h0005, v); chk("R1 second program is AND", v, 16'h1204);

        // R8 busy length, R6/R7 status reads
        cur_req = "R8";
        prog_seq(16'h0006, 16'h0080);
        n = 0;
        @(negedge clk);
        while (busy) begin n++; @(negedge clk); end
        chk("R8 busy cycle count", 16'(n), 16'(NBUSY));
        cur_req = "R6";
        prog_seq(16'h0007, 16'h0080);
        rd(16'h0007, v); chk("R6 status first read", v, 16'h8000);
        cur_req = "R7";
        rd(16'h0007, v); chk("R7 toggle after one read", v, 16'hC040);
        rd(16'h0007, v); chk("R7 toggle after two reads", v, 16'h8000);
        wait_idle();
        rd(16'h0007, v); chk("R6 data after busy", v, 16'h0080);

        // R8 writes during busy ignored
        cur_req = "R8";
        prog_seq(16'h0008, 16'h5555);
        id_seq();
        wait_idle();
        rd(16'h0000, v); chk("R8 id entry during busy ignored", v, 16'hFFFF);

        // R9 broken handshake
        cur_req = "R9";
        wr(16'h5555, 16'h00AA); wr(16'h2AAA, 16'h0056); wr(16'h5555, 16'h00A0); wr(16'h0009, 16'h0000);
        @(negedge clk);
        chk("R9 no busy after broken handshake", {15'b0, busy}, 16'h0);
        rd(16'h0009, v); chk("R9 word unchanged", v, 16'hFFFF);

        // R10 masked compare
        cur_req = "R10";
        wr(16'hD555, 16'h12AA); wr(16'hAAAA, 16'h3455); wr(16'hD555, 16'h77A0); wr(16'h000A, 16'h00F0);
        wait_idle();
        rd(16'h000A, v); chk("R10 masked handshake programs", v, 16'h00F0);

        // R3 identification mode
        cur_req = "R3";
        id_seq();
        rd(16'h0000, v); chk("R3 manufacturer code", v, MID);
        rd(16'h0001, v); chk("R3 device code", v, DID);
        rd(16'h0002, v); chk("R3 lock status clear", v, 16'h0000);
        wr(16'h0000, 16'h00F0);
        rd(16'h0005, v); chk("R3 exit returns array data", v, 16'h1204);

        // R4 lock of boot region
        cur_req = "R4";
        ext_seq(16'h0040);
        id_seq();
        rd(16'h0002, v); chk("R4 lock status set", v, 16'h0001);
        wr(16'h1234, 16'h00F0);
        prog_seq(16'h0003, 16'h0000);
        @(negedge clk);
        chk("R4 locked program no busy", {15'b0, busy}, 16'h0);
        rd(16'h0003, v); chk("R4 locked word unchanged", v, 16'hFFFF);
        prog_seq(16'h0020, 16'h00FF); wait_idle();
        rd(16'h0020, v); chk("R4 unlocked word programs", v, 16'h00FF);

        // R2 erase
        cur_req = "R2";
        ext_seq(16'h0010);
        rd(16'h0020, v); chk("R6 erase status", v, 16'h0000);
        wait_idle();
        rd(16'h0005, v); chk("R2 word 5 erased", v, 16'hFFFF);
        rd(16'h0020, v); chk("R2 word 20h erased", v, 16'hFFFF);
        rd(16'h00FF, v); chk("R2 last word erased", v, 16'hFFFF);

        repeat (3) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule